// File: doc/BRIEF.md
# Heat-Spreading H-Bridge Gate Sequencer

This block drives the four gate controls of a full H-bridge so that the heat of the off-time current is shared among all four switches. It does not map the PWM phase onto the gates the same way in every period. It steps through a short rotation of per-period patterns. Each pattern routes the off-time (recirculation) current through a different switch or body diode. Two rotations are offered:

- A two-period synchronous sign-magnitude rotation.
- A four-period asynchronous sign-magnitude rotation.

The duty-cycle generator sits upstream. It supplies the on/off phase and a one-cycle strobe at the start of each PWM period. The sequencer keeps a period index that advances on every strobe. Dead-time insertion stays downstream.

These rotations keep switching even at zero duty, so the bridge has no natural off state. For that reason the block has two ways to quench the outputs:

- Enable: stops and rewinds the rotation.
- Power-down: forces all gates off while the rotation keeps counting.

Gate bits use the order gate[0] = Q1 (high side, half-bridge a), gate[1] = Q2 (low side, a), gate[2] = Q3 (high side, b), gate[3] = Q4 (low side, b). A 1 means conduct.

Top module: `hb_heat_seq`

## Requirements
- R1: While rst_n is low and after its release, with no period strobe yet seen, gate is 4'b0000.
- R2: While enable is low, gate is 0 and the sequence is stopped. After enable rises, gate stays 0 until the first period_start. From the cycle after that strobe, the block outputs period 1 of the selected rotation.
- R3: While pwr_down is high, gate is 0 in the same cycle. The period index keeps advancing on strobes. When pwr_down falls, the pattern of the current period appears at once.
- R4: In forward direction (dir_fwd=1), every on-time cycle (pwm_on=1) of both rotations drives Q1 and Q4 only, i.e. gate=4'b1001.
- R5: Two-period rotation (mode_sel=0), forward: the off-time (pwm_on=0) of period 1 drives Q1 and Q3 (gate=4'b0101). The off-time of period 2 drives Q2 and Q4 (gate=4'b1010). So each switch turns on and off once per two periods.
- R6: Four-period rotation (mode_sel=1), forward: the off-time of periods 1 to 4 drives only Q1 (4'b0001), then only Q3 (4'b0100), then only Q4 (4'b1000), then only Q2 (4'b0010).
- R7: In reverse (dir_fwd=0), every pattern is the forward one with Q1 exchanged for Q3 and Q2 for Q4. On-time is then gate=4'b0110.
- R8: While running, each period_start advances the period one step, from the cycle after the strobe. The index wraps from period 2 (two-period) or period 4 (four-period) back to period 1.
- R9: A change of dir_fwd or mode_sel restarts the rotation at period 1, from the next cycle. This takes priority over a strobe in the same cycle.
- R10: Q1 and Q2 are never on together, nor are Q3 and Q4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the rotation; low forces gates off and rewinds |
| pwr_down | input | 1 | Forces all gates off without stopping the count |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| pwm_on | input | 1 | 1 during the on-time, 0 during the off-time |
| dir_fwd | input | 1 | 1 forward, 0 reverse |
| mode_sel | input | 1 | 0 two-period rotation, 1 four-period rotation |
| gate | output | 4 | Gate controls Q1..Q4 in bits 0..3, active high |

## Verification
The bench builds the block with its default rotation lengths of two and four periods. It exercises both wrap points of the shared period index, as well as both orientations of the half-bridge exchange. Several full rotations are run in each mode and direction. Direction and mode changes are placed both in mid-period and on a strobe cycle, so the restart priority is visible. Power-down and enable are dropped and raised mid-rotation. This shows that the count continues in the first case and rewinds in the second.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

   typedef enum logic {
      ROT_SYNC2  = 1'b0,
      ROT_ASYNC4 = 1'b1
   } rot_mode_e;

   localparam int unsigned GATES_PER_BRIDGE = 4;

endpackage

// File: rtl/hb_seq_counter.sv
module hb_seq_counter
   import hb_seq_pkg::*;
#(
   parameter int unsigned SHORT_LEN = 2,
   parameter int unsigned LONG_LEN  = 4,
   parameter int unsigned IDX_W     = $clog2(LONG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             period_start,
   input  logic             dir_fwd,
   input  rot_mode_e        mode,
   output logic             running,
   output logic [IDX_W-1:0] idx,
   output logic             dir_q,
   output rot_mode_e        mode_q
);

   localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
   localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

   logic             restart;
   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] idx_next;

   assign restart  = (dir_fwd != dir_q) || (mode != mode_q);
   assign last_idx = (mode_q == ROT_ASYNC4) ? LONG_LAST : SHORT_LAST;
   assign idx_next = (idx == last_idx) ? '0 : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         idx     <= '0;
         dir_q   <= 1'b0;
         mode_q  <= ROT_SYNC2;
      end else begin
         dir_q  <= dir_fwd;
         mode_q <= mode;
         if (!enable) begin
            running <= 1'b0;
            idx     <= '0;
         end else if (restart) begin
            idx <= '0;
         end else if (period_start) begin
            if (!running) begin
               running <= 1'b1;
               idx     <= '0;
            end else begin
               idx <= idx_next;
            end
         end
      end
   end

endmodule

// File: rtl/hb_seq_pattern.sv
module hb_seq_pattern
   import hb_seq_pkg::*;
#(
   parameter int unsigned IDX_W = 2
) (
   input  logic                        pwm_on,
   input  rot_mode_e                   mode_q,
   input  logic [IDX_W-1:0]            idx,
   output logic [GATES_PER_BRIDGE-1:0] fwd_gate
);

   // bit order: [0]=a-high, [1]=a-low, [2]=b-high, [3]=b-low
   always_comb begin
      if (pwm_on) begin
         fwd_gate = 4'b1001;
      end else if (mode_q == ROT_SYNC2) begin
         fwd_gate = idx[0] ? 4'b1010 : 4'b0101;
      end else begin
         unique case (idx[1:0])
            2'd0:    fwd_gate = 4'b0001;
            2'd1:    fwd_gate = 4'b0100;
            2'd2:    fwd_gate = 4'b1000;
            default: fwd_gate = 4'b0010;
         endcase
      end
   end

endmodule

// File: rtl/hb_seq_orient.sv
module hb_seq_orient
   import hb_seq_pkg::*;
(
   input  logic                        dir_q,
   input  logic [GATES_PER_BRIDGE-1:0] fwd_gate,
   output logic [GATES_PER_BRIDGE-1:0] gate_o
);

   localparam int unsigned HALVES = GATES_PER_BRIDGE / 2;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      for (genvar s = 0; s < 2; s++) begin : g_side
         localparam int unsigned OWN  = 2 * h + s;
         localparam int unsigned PEER = 2 * (HALVES - 1 - h) + s;
         assign gate_o[OWN] = dir_q ? fwd_gate[OWN] : fwd_gate[PEER];
      end
   end

endmodule

// File: rtl/hb_heat_seq.sv
module hb_heat_seq
   import hb_seq_pkg::*;
#(
   parameter int unsigned SHORT_LEN = 2,
   parameter int unsigned LONG_LEN  = 4,
   parameter int unsigned GATE_W    = 4,
   localparam int unsigned IDX_W    = $clog2(LONG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              pwr_down,
   input  logic              period_start,
   input  logic              pwm_on,
   input  logic              dir_fwd,
   input  logic              mode_sel,
   output logic [GATE_W-1:0] gate
);

   if (SHORT_LEN != 2) begin : g_bad_short
      $error("hb_heat_seq: SHORT_LEN must be 2");
   end
   if (LONG_LEN != 4) begin : g_bad_long
      $error("hb_heat_seq: LONG_LEN must be 4");
   end
   if (GATE_W != GATES_PER_BRIDGE) begin : g_bad_width
      $error("hb_heat_seq: GATE_W must be 4");
   end

   logic             run_w;
   logic [IDX_W-1:0] idx_w;
   logic             dir_q_w;
   rot_mode_e        mode_q_w;
   rot_mode_e        mode_in;
   logic [GATES_PER_BRIDGE-1:0] fwd_w;
   logic [GATES_PER_BRIDGE-1:0] oriented_w;

   assign mode_in = rot_mode_e'(mode_sel);

   hb_seq_counter #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .IDX_W     (IDX_W)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .period_start (period_start),
      .dir_fwd      (dir_fwd),
      .mode         (mode_in),
      .running      (run_w),
      .idx          (idx_w),
      .dir_q        (dir_q_w),
      .mode_q       (mode_q_w)
   );

   hb_seq_pattern #(
      .IDX_W (IDX_W)
   ) u_pat (
      .pwm_on   (pwm_on),
      .mode_q   (mode_q_w),
      .idx      (idx_w),
      .fwd_gate (fwd_w)
   );

   hb_seq_orient u_ori (
      .dir_q    (dir_q_w),
      .fwd_gate (fwd_w),
      .gate_o   (oriented_w)
   );

   assign gate = (enable && !pwr_down && run_w) ? oriented_w : '0;

endmodule

// File: rtl/hb_heat_seq_chk.sv
module hb_heat_seq_chk #(
   parameter int unsigned SHORT_LEN = 2,
   parameter int unsigned LONG_LEN  = 4,
   parameter int unsigned IDX_W     = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             pwr_down,
   input logic             period_start,
   input logic             pwm_on,
   input logic             dir_fwd,
   input logic             mode_sel,
   input logic [3:0]       gate,
   input logic             running,
   input logic [IDX_W-1:0] idx,
   input logic             dir_q,
   input logic             mode_q
);

   logic             changed;
   logic [IDX_W-1:0] wrap_at;
   logic [IDX_W-1:0] step_to;

   assign changed = (dir_fwd != dir_q) || (mode_sel != mode_q);
   assign wrap_at = mode_q ? IDX_W'(LONG_LEN - 1) : IDX_W'(SHORT_LEN - 1);
   assign step_to = (idx == wrap_at) ? '0 : idx + 1'b1;

   assert_pd_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> gate == 4'b0000);

   assert_en_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> gate == 4'b0000);

   assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> gate == 4'b0000);

   assert_no_shoot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[0] && gate[1]) && !(gate[2] && gate[3]));

   assert_on_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && gate != 4'b0000) |-> $countones(gate) == 2);

   assert_single_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_on && mode_q && gate != 4'b0000) |-> $countones(gate) == 1);

   assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && running && period_start && !changed) |=> idx == $past(step_to));

   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && changed) |=> idx == '0);

endmodule

bind hb_heat_seq hb_heat_seq_chk #(
   .SHORT_LEN (SHORT_LEN),
   .LONG_LEN  (LONG_LEN),
   .IDX_W     (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .pwr_down     (pwr_down),
   .period_start (period_start),
   .pwm_on       (pwm_on),
   .dir_fwd      (dir_fwd),
   .mode_sel     (mode_sel),
   .gate         (gate),
   .running      (run_w),
   .idx          (idx_w),
   .dir_q        (dir_q_w),
   .mode_q       (mode_q_w)
);

// File: tb/hb_heat_seq_tb_top.sv
`timescale 1ns/1ps
module hb_heat_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       pwr_down = 1'b0;
   logic       period_start = 1'b0;
   logic       pwm_on = 1'b0;
   logic       dir_fwd = 1'b1;
   logic       mode_sel = 1'b0;
   logic [3:0] gate;

   always #2 clk = ~clk;

   hb_heat_seq dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .pwr_down     (pwr_down),
      .period_start (period_start),
      .pwm_on       (pwm_on),
      .dir_fwd      (dir_fwd),
      .mode_sel     (mode_sel),
      .gate         (gate)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit stim_done = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   // bench reference state (what the registers hold after the next edge)
   bit       m_run  = 1'b0;
   int       m_per  = 0;
   bit       m_dir  = 1'b0;
   bit       m_mode = 1'b0;

   // Q1..Q4 -> bits 0..3
   function automatic logic [3:0] q_set(bit q1, bit q2, bit q3, bit q4);
      return {q4, q3, q2, q1};
   endfunction

   function automatic logic [3:0] ref_gate(bit fwd, bit four, int per, bit on);
      logic [3:0] f;
      if (on)
         f = q_set(1, 0, 0, 1);                       // R4
      else if (!four)
         f = (per % 2 == 0) ? q_set(1, 0, 1, 0)       // R5 period 1
                            : q_set(0, 1, 0, 1);      // R5 period 2
      else
         case (per)
            0:       f = q_set(1, 0, 0, 0);           // R6
            1:       f = q_set(0, 0, 1, 0);
            2:       f = q_set(0, 0, 0, 1);
            default: f = q_set(0, 1, 0, 0);
         endcase
      if (fwd) return f;
      return q_set(f[2], f[3], f[0], f[1]);           // R7 exchange
   endfunction

   task automatic drive(bit rst, bit en, bit pd, bit fwd, bit four,
                        bit strobe, bit on, string tag);
      logic [3:0] e;
      @(negedge clk);
      rst_n = rst; enable = en; pwr_down = pd; dir_fwd = fwd;
      mode_sel = four; period_start = strobe; pwm_on = on;
      if (!rst || !en || pd || !m_run) e = 4'b0000;
      else e = ref_gate(m_dir, m_mode, m_per, on);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (!rst) begin
         m_run = 0; m_per = 0; m_dir = 0; m_mode = 0;
      end else begin
         if (!en) begin
            m_run = 0; m_per = 0;
         end else if (fwd != m_dir || four != m_mode) begin
            m_per = 0;
         end else if (strobe) begin
            if (!m_run) begin m_run = 1; m_per = 0; end
            else m_per = (m_per + 1) % (m_mode ? 4 : 2);
         end
         m_dir = fwd; m_mode = four;
      end
   endtask

   task automatic run_periods(int n, bit pd, bit fwd, bit four, string tag);
      for (int p = 0; p < n; p++) begin
         for (int c = 0; c < 6; c++)
            drive(1, 1, pd, fwd, four, c == 0, c > 0 && c < 3, tag);
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (gate !== e) begin
               n_fail++;
               $display("FAIL %s: gate=%b expected=%b at %0t", t, gate, e, $time);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!stim_done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset and idle after reset
      for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 0, 0, 1, "R1");
      for (int i = 0; i < 3; i++) drive(1, 0, 0, 1, 0, 0, 1, "R1");
      // R2: enable low ignores strobes
      drive(1, 0, 0, 1, 0, 1, 1, "R2");
      drive(1, 0, 0, 1, 0, 0, 0, "R2");
      // R2: enabled but waiting for first strobe
      for (int i = 0; i < 3; i++) drive(1, 1, 0, 1, 0, 0, i == 0, "R2");
      // R4 R5 R8: two-period forward
      run_periods(5, 0, 1, 0, "R5");
      // R3: power-down keeps count, then release
      run_periods(3, 1, 1, 0, "R3");
      run_periods(2, 0, 1, 0, "R3");
      // R9 + R6: switch to four-period (change mid-period)
      drive(1, 1, 0, 1, 1, 0, 0, "R9");
      run_periods(6, 0, 1, 1, "R6");
      // R7: reverse, change on a strobe cycle
      drive(1, 1, 0, 0, 1, 1, 1, "R9");
      run_periods(5, 0, 0, 1, "R7");
      run_periods(3, 0, 0, 0, "R7");
      // R9: direction flip mid-period in two-period mode
      for (int i = 0; i < 4; i++) drive(1, 1, 0, 1, 0, 0, 0, "R9");
      run_periods(3, 0, 1, 0, "R8");
      // R2: drop and raise enable mid-rotation
      drive(1, 0, 0, 1, 0, 1, 1, "R2");
      drive(1, 0, 0, 1, 0, 0, 0, "R2");
      for (int i = 0; i < 3; i++) drive(1, 1, 0, 1, 0, 0, 0, "R2");
      run_periods(3, 0, 1, 1, "R10");
      drive(1, 1, 0, 1, 1, 0, 0, "R10");
      repeat (3) @(negedge clk);
      stim_done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule